// File: doc/BRIEF.md
# Torus Dimension-Order Port Selector

This block sits at the input of a switch in a k-ary d-cube (torus) network and decides which output port a packet leaves by. It looks only at the destination coordinates carried in the packet's header flit, so the decision is ready before the body of the packet arrives and the packet can be forwarded cut-through. The switch's own coordinates are fixed by parameters.

Routing is deterministic and minimal. Offsets are removed one dimension at a time, lowest dimension first. Within the chosen dimension the block takes the shorter way around the ring, using the wraparound link when that is shorter. A header whose coordinates all match the local switch is sent to the ejection port. Each decision is registered and presented on a valid/ready output. A header is accepted when the output register is empty, or when it is being drained in the same cycle. While the consumer holds ready low, the decision stays on the output unchanged and no new header is taken.

Top module: `tr_route_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `port_valid` is 0 and `hdr_ready` is 1.
- R2: A header whose coordinates all equal the local coordinates selects the ejection port, code 2·DIMS (6 by default).
- R3: The destination is packed with dimension i at bits [i·COORD_W +: COORD_W]. The selected dimension is the lowest one whose destination coordinate differs from the local one. Higher dimensions have no effect on the choice while a lower one differs.
- R4: Port code 2·i means the plus direction in dimension i. It is chosen when the plus distance (dest − local) mod RADIX is less than half of RADIX. Destination coordinates are in the range 0 to RADIX−1.
- R5: Port code 2·i+1 means the minus direction in dimension i. It is chosen when the plus distance is more than half of RADIX, including when the shorter way uses the wraparound link.
- R6: When RADIX is even and the plus distance is exactly RADIX/2, the plus direction (code 2·i) is chosen.
- R7: A header accepted on a clock edge (`hdr_valid` and `hdr_ready` both 1) gives `port_valid` = 1 with its port code right after that edge.
- R8: While `port_valid` is 1 and `port_ready` is 0, `port_valid` stays 1, `port_sel` stays stable and `hdr_ready` is 0.
- R9: With `port_ready` held at 1, a header can be accepted on every cycle, and each decision depends only on its own header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | A header is offered |
| hdr_ready | output | 1 | The header is taken on this edge |
| hdr_dest | input | DIMS·COORD_W | Destination coordinates, dimension i at bits [i·COORD_W +: COORD_W] |
| port_valid | output | 1 | A port decision is held |
| port_ready | input | 1 | The consumer takes the decision |
| port_sel | output | PORT_W | Port code: 2·i plus, 2·i+1 minus, 2·DIMS ejection |

## Verification
The assertions assume that every destination coordinate offered with `hdr_valid` is below RADIX. One property checks this at the input. The stimulus only drives coordinates from 0 to 3 for the default radix of 4. The hold properties also assume that the consumer lowers `port_ready` only between clock edges. The bench changes inputs only on falling edges, so this holds.

// File: rtl/tr_route_pkg.sv
package tr_route_pkg;

  // Per-dimension routing request produced by each offset unit.
  typedef struct packed {
    logic active;  // offset in this dimension is non-zero
    logic minus;   // shorter way is the minus direction
  } dim_req_t;

endpackage

// File: rtl/tr_dim_offset.sv
module tr_dim_offset
  import tr_route_pkg::*;
#(
  parameter int unsigned RADIX   = 4,
  parameter int unsigned COORD_W = 2,
  parameter int unsigned LOCAL   = 0
) (
  input  logic [COORD_W-1:0] dest,
  output dim_req_t           req
);
  localparam int unsigned EXT_W = COORD_W + 2;
  localparam logic [EXT_W-1:0] RADIX_E = EXT_W'(RADIX);
  localparam logic [EXT_W-1:0] LOCAL_E = EXT_W'(LOCAL);

  logic [EXT_W-1:0] dest_e;
  logic [EXT_W-1:0] plus_dist;
  logic [EXT_W:0]   twice_dist;

  always_comb begin
    dest_e = EXT_W'(dest);
    // Hops needed going the plus way around the ring.
    if (dest_e >= LOCAL_E) plus_dist = dest_e - LOCAL_E;
    else                   plus_dist = dest_e + RADIX_E - LOCAL_E;
    twice_dist = {plus_dist, 1'b0};
    req.active = (plus_dist != '0);
    // Ties (exactly half the ring) go plus.
    req.minus  = (twice_dist > {1'b0, RADIX_E});
  end

endmodule

// File: rtl/tr_port_pick.sv
module tr_port_pick
  import tr_route_pkg::*;
#(
  parameter int unsigned DIMS   = 3,
  parameter int unsigned PORT_W = 3
) (
  input  dim_req_t [DIMS-1:0] req,
  output logic [PORT_W-1:0]   sel
);
  localparam logic [PORT_W-1:0] EJECT = PORT_W'(2 * DIMS);

  always_comb begin
    sel = EJECT;
    // Walk from the top down so the lowest active dimension wins.
    for (int i = DIMS - 1; i >= 0; i--) begin
      if (req[i].active) sel = PORT_W'(2 * i) | PORT_W'(req[i].minus);
    end
  end

endmodule

// File: rtl/tr_port_reg.sv
module tr_port_reg #(
  parameter int unsigned PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PORT_W-1:0] in_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_sel
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sel   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_sel <= in_sel;
    end
  end

  // R7: an accepted header shows up on the next cycle.
  a_r7_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: a stalled decision is held unchanged.
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sel));

  // R8: nothing is taken while stalled.
  a_r8_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && in_valid |=> $stable(out_sel));

endmodule

// File: rtl/tr_route_unit.sv
module tr_route_unit
  import tr_route_pkg::*;
#(
  parameter int unsigned RADIX   = 4,
  parameter int unsigned DIMS    = 3,
  parameter int unsigned COORD_W = $clog2(RADIX),
  parameter logic [DIMS*COORD_W-1:0] LOCAL_COORD = 'd57,
  parameter int unsigned PORT_W  = $clog2(2 * DIMS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hdr_valid,
  output logic                    hdr_ready,
  input  logic [DIMS*COORD_W-1:0] hdr_dest,
  output logic                    port_valid,
  input  logic                    port_ready,
  output logic [PORT_W-1:0]       port_sel
);
  localparam logic [PORT_W-1:0] EJECT = PORT_W'(2 * DIMS);

  dim_req_t [DIMS-1:0] dim_req;
  logic [PORT_W-1:0]   next_sel;

  for (genvar g = 0; g < DIMS; g++) begin : g_dim
    tr_dim_offset #(
      .RADIX  (RADIX),
      .COORD_W(COORD_W),
      .LOCAL  (int'(LOCAL_COORD[g*COORD_W +: COORD_W]))
    ) offset_i (
      .dest(hdr_dest[g*COORD_W +: COORD_W]),
      .req (dim_req[g])
    );

    // R4: coordinates offered must lie on the ring.
    a_r4_dest_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> (int'(hdr_dest[g*COORD_W +: COORD_W]) < RADIX));
  end

  tr_port_pick #(
    .DIMS  (DIMS),
    .PORT_W(PORT_W)
  ) pick_i (
    .req(dim_req),
    .sel(next_sel)
  );

  tr_port_reg #(
    .PORT_W(PORT_W)
  ) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (hdr_valid),
    .in_ready (hdr_ready),
    .in_sel   (next_sel),
    .out_valid(port_valid),
    .out_ready(port_ready),
    .out_sel  (port_sel)
  );

  // R2: a header addressed to this switch leaves by the ejection port.
  a_r2_local_eject: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready && (hdr_dest == LOCAL_COORD) |=> port_sel == EJECT);

  // R3: any held decision carries a legal port code.
  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid |-> port_sel <= EJECT);

  // R2: ejection is never chosen while some dimension still differs.
  a_r2_no_early_eject: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready && (hdr_dest != LOCAL_COORD) |=> port_sel != EJECT);

endmodule

// File: tb/tr_route_unit_tb_top.sv
`timescale 1ns/1ps
module tr_route_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hdr_valid;
  logic       hdr_ready;
  logic [5:0] hdr_dest;
  logic       port_valid;
  logic       port_ready;
  logic [2:0] port_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tr_route_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_dest(hdr_dest),
    .port_valid(port_valid), .port_ready(port_ready), .port_sel(port_sel)
  );

  // Local coordinates (x2,x1,x0) = (3,2,1), radix 4. {dest, expected port}
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    {6'd57, 3'd6},  // R2 all equal -> eject
    {6'd58, 3'd0},  // R4 dim0 +1
    {6'd56, 3'd1},  // R5 dim0 -1 via wrap
    {6'd59, 3'd0},  // R6 dim0 tie -> plus
    {6'd61, 3'd2},  // R4 dim1 +1
    {6'd53, 3'd3},  // R5 dim1 -1
    {6'd49, 3'd2},  // R6 dim1 tie
    {6'd9,  3'd4},  // R4 dim2 +1 via wrap
    {6'd41, 3'd5},  // R5 dim2 -1
    {6'd25, 3'd4},  // R6 dim2 tie
    {6'd8,  3'd1},  // R3 dims 0,2 differ -> dim0
    {6'd33, 3'd2},  // R3 dims 1,2 differ -> dim1
    {6'd0,  3'd1}   // R3 all differ -> dim0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_one(input logic [5:0] d, input logic [2:0] exp, input string req);
    hdr_valid = 1'b1;
    hdr_dest  = d;
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    check({req, " valid"}, 32'(port_valid), 32'd1);
    check({req, " port"},  32'(port_sel),   32'(exp));
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hdr_valid = 1'b0; hdr_dest = '0; port_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", 32'(port_valid), 32'd0);
    check("R1 reset ready", 32'(hdr_ready),  32'd1);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 post-reset valid", 32'(port_valid), 32'd0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      send_one(VEC[i][8:3], VEC[i][2:0], $sformatf("R2-6 vec%0d", i));
      @(posedge clk);
      @(negedge clk);
    end

    // R8: back-pressure holds the decision and blocks input
    port_ready = 1'b0;
    send_one(6'd58, 3'd0, "R8 first");
    hdr_valid = 1'b1;
    hdr_dest  = 6'd56;
    #1;
    check("R8 ready low", 32'(hdr_ready), 32'd0);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      @(negedge clk);
      check("R8 held valid", 32'(port_valid), 32'd1);
      check("R8 held port",  32'(port_sel),   32'd0);
    end
    port_ready = 1'b1;
    #1;
    check("R8 ready on drain", 32'(hdr_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    check("R8 next valid", 32'(port_valid), 32'd1);
    check("R8 next port",  32'(port_sel),   32'd1);
    @(posedge clk);
    @(negedge clk);
    check("R7 drained", 32'(port_valid), 32'd0);

    // R9: back-to-back stream, one per cycle
    for (int i = 7; i < NV; i++) begin
      hdr_valid = 1'b1;
      hdr_dest  = VEC[i][8:3];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R9 stream%0d valid", i), 32'(port_valid), 32'd1);
      check($sformatf("R9 stream%0d port", i),  32'(port_sel),   32'(VEC[i][2:0]));
    end
    send_one(6'd59, 3'd0, "R9 repeat tie");
    @(posedge clk);
    @(negedge clk);
    check("R7 idle after stream", 32'(port_valid), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule